// File: doc/BRIEF.md
# Load-Store Memory Ordering Guard

This block sits next to a reorder buffer and decides, every cycle, whether a pending load may begin its memory access and whether the oldest store may write memory. It keeps one entry for each in-flight store. Each entry holds the store's reorder-buffer index and its effective address once that address is known. It also holds the store data, or the tag of the instruction that will produce that data. A load is allowed through only when no older live store could write the location it reads. Stores reach memory strictly one at a time, from the head of the reorder buffer, so memory updates follow program order.

Ages are reorder-buffer indices taken relative to the current head, so an index that has wrapped past zero still counts as younger than the head. A store entry is freed when its commit handshake completes, or when a flush discards the speculative work it belongs to. The load grant is combinational. If the only store holding a load back commits in a given cycle, the load is granted in that same cycle.

Top module: `lsog_order_guard`

## Requirements
- R1: After reset no store entry is live: `st_alloc_ready_o` is 1, `st_commit_valid_o` is 0, and a requested load is granted whatever its index and address.
- R2: A requested load is refused (`ld_grant_o` = 0) while any live store that is older than it has a known address equal to the load address.
- R3: A requested load is refused while any live store that is older than it has not yet received its address. An address written with `st_addr_valid_i` takes effect from the next cycle.
- R4: Stores that are younger than the load, and older stores whose known address differs from the load address, do not hold the load back. With no request, `ld_grant_o` is 0.
- R5: Age is the index minus `rob_head_i`, taken modulo the reorder-buffer depth (a power of two). A smaller difference means older, which stays correct when indices wrap past zero.
- R6: `st_commit_valid_o` is 1 exactly when the live store whose index equals `rob_head_i` has both its address and its data. The address and data of that store are then driven on `st_commit_addr_o` and `st_commit_data_o`.
- R7: A store's data is taken from the allocate port when `st_alloc_data_rdy_i` is 1. Otherwise it is taken from the first result broadcast whose tag equals the recorded producer tag, including a broadcast in the same cycle as the allocate. Once captured, the data does not change.
- R8: A commit completes when `st_commit_valid_o` and `st_commit_ready_i` are both 1. It frees the entry, and the freed store stops holding back loads in that same cycle.
- R9: A flush discards every live store whose age is greater than the age of `flush_rob_i`. An allocate in the same cycle as a flush is dropped.
- R10: `st_alloc_ready_o` is 0 while all store entries are live, and an allocate offered then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rob_head_i | input | IDX_W | Index of the oldest reorder-buffer entry |
| st_alloc_valid_i | input | 1 | Allocate a store entry |
| st_alloc_rob_i | input | IDX_W | Reorder-buffer index of the new store |
| st_alloc_data_rdy_i | input | 1 | Store data is present on the allocate port |
| st_alloc_data_i | input | DATA_W | Store data when ready |
| st_alloc_tag_i | input | IDX_W | Producer tag of the data when not ready |
| st_alloc_ready_o | output | 1 | A free store entry exists |
| st_addr_valid_i | input | 1 | A store's effective address is available |
| st_addr_rob_i | input | IDX_W | Index of the store receiving the address |
| st_addr_i | input | ADDR_W | Effective address |
| res_valid_i | input | 1 | Result broadcast valid |
| res_tag_i | input | IDX_W | Tag of the broadcast result |
| res_data_i | input | DATA_W | Broadcast result value |
| ld_req_valid_i | input | 1 | A load asks to access memory |
| ld_req_rob_i | input | IDX_W | Reorder-buffer index of the load |
| ld_req_addr_i | input | ADDR_W | Load effective address |
| ld_grant_o | output | 1 | The load may access memory this cycle |
| st_commit_valid_o | output | 1 | The head store can write memory |
| st_commit_ready_i | input | 1 | Memory accepts the store write |
| st_commit_addr_o | output | ADDR_W | Address of the committing store |
| st_commit_data_o | output | DATA_W | Data of the committing store |
| flush_i | input | 1 | Discard stores younger than the flush point |
| flush_rob_i | input | IDX_W | Index of the youngest surviving instruction |

## Verification
The assertions rely on the following properties of the inputs:
- Each live store has a distinct reorder-buffer index.
- An address is written only to a store that is already live.
- The head does not advance past a store that has not committed.
- A flush point never lies below the head.

The stimulus models the reorder buffer as a head pointer and a tail pointer. New indices are handed out only at the tail. Addresses go only to live stores that still lack one. The head moves past a store only on a completed commit, and flush points are drawn from the occupied range. Inside those limits, allocates are still offered deliberately while all entries are full, and flushes land on cycles that also carry allocates and commits.

// File: rtl/lsog_pkg.sv
package lsog_pkg;

  // Why a store entry holds a load back.
  typedef enum logic [1:0] {
    HOLD_NONE       = 2'd0,
    HOLD_UNRESOLVED = 2'd1,
    HOLD_ALIAS      = 2'd2
  } hold_e;

endpackage

// File: rtl/lsog_alloc.sv
module lsog_alloc #(
  parameter int N = 8
) (
  input  logic [N-1:0] busy_i,
  input  logic         req_i,
  output logic [N-1:0] pick_o,
  output logic         has_free_o
);

  logic [N-1:0] free_vec;
  logic         found;

  assign free_vec   = ~busy_i;
  assign has_free_o = |free_vec;

  // Lowest free entry wins.
  always_comb begin
    pick_o = '0;
    found  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i && free_vec[i] && !found) begin
        pick_o[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/lsog_commit_mux.sv
module lsog_commit_mux #(
  parameter int N      = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic [N-1:0]             head_hit_i,
  input  logic [N-1:0]             addr_vld_i,
  input  logic [N-1:0]             data_vld_i,
  input  logic [N-1:0][ADDR_W-1:0] addr_i,
  input  logic [N-1:0][DATA_W-1:0] data_i,
  output logic                     valid_o,
  output logic [ADDR_W-1:0]        addr_o,
  output logic [DATA_W-1:0]        data_o
);

  // At most one entry matches the head, so an AND-OR select is enough.
  always_comb begin
    valid_o = 1'b0;
    addr_o  = '0;
    data_o  = '0;
    for (int i = 0; i < N; i++) begin
      valid_o = valid_o | (head_hit_i[i] & addr_vld_i[i] & data_vld_i[i]);
      addr_o  = addr_o  | ({ADDR_W{head_hit_i[i]}} & addr_i[i]);
      data_o  = data_o  | ({DATA_W{head_hit_i[i]}} & data_i[i]);
    end
  end

endmodule

// File: rtl/lsog_slot.sv
module lsog_slot
  import lsog_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  head_i,
  input  logic              alloc_hit_i,
  input  logic [IDX_W-1:0]  alloc_rob_i,
  input  logic              alloc_data_rdy_i,
  input  logic [DATA_W-1:0] alloc_data_i,
  input  logic [IDX_W-1:0]  alloc_tag_i,
  input  logic              addr_we_i,
  input  logic [IDX_W-1:0]  addr_rob_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              res_valid_i,
  input  logic [IDX_W-1:0]  res_tag_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic              flush_i,
  input  logic [IDX_W-1:0]  flush_rob_i,
  input  logic              commit_fire_i,
  input  logic [IDX_W-1:0]  ld_rob_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  output logic              vld_o,
  output logic              head_hit_o,
  output logic              addr_vld_o,
  output logic              data_vld_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output hold_e             hold_o
);

  logic              vld_q, vld_d;
  logic              av_q, av_d;
  logic              dv_q, dv_d;
  logic [IDX_W-1:0]  rob_q, tag_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, data_d;

  logic [IDX_W-1:0]  age_self, age_flush, age_ld;
  logic              head_hit, retire, squash, clr;
  logic              addr_hit, res_hit_live, res_hit_new;
  logic              meta_en, addr_en, data_en;
  logic              older;

  // Age relative to the head: modulo subtraction handles wrap.
  assign age_self  = rob_q - head_i;
  assign age_flush = flush_rob_i - head_i;
  assign age_ld    = ld_rob_i - head_i;

  assign head_hit     = vld_q && (rob_q == head_i);
  assign retire       = head_hit && commit_fire_i;
  assign squash       = flush_i && vld_q && (age_self > age_flush);
  assign clr          = retire || squash;
  assign addr_hit     = vld_q && !clr && addr_we_i && (addr_rob_i == rob_q);
  assign res_hit_live = vld_q && !clr && !dv_q && res_valid_i && (res_tag_i == tag_q);
  assign res_hit_new  = res_valid_i && (res_tag_i == alloc_tag_i);

  assign meta_en = alloc_hit_i;
  assign addr_en = addr_hit;
  assign data_en = alloc_hit_i || res_hit_live;

  // Next-state
  always_comb begin
    vld_d  = vld_q;
    av_d   = av_q;
    dv_d   = dv_q;
    data_d = res_data_i;
    if (alloc_hit_i) begin
      vld_d  = 1'b1;
      av_d   = 1'b0;
      dv_d   = alloc_data_rdy_i || res_hit_new;
      data_d = alloc_data_rdy_i ? alloc_data_i : res_data_i;
    end else begin
      if (clr)          vld_d = 1'b0;
      if (addr_hit)     av_d  = 1'b1;
      if (res_hit_live) dv_d  = 1'b1;
    end
  end

  // Control state, reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      av_q  <= 1'b0;
      dv_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      av_q  <= av_d;
      dv_q  <= dv_d;
    end
  end

  // Payload, enabled, not reset
  always_ff @(posedge clk) begin
    if (meta_en) begin
      rob_q <= alloc_rob_i;
      tag_q <= alloc_tag_i;
    end
    if (addr_en) addr_q <= addr_i;
    if (data_en) data_q <= data_d;
  end

  // Load ordering: an older live store that is not retiring this cycle.
  assign older = vld_q && (age_self < age_ld) && !retire;

  always_comb begin
    hold_o = HOLD_NONE;
    if (older && !av_q)                          hold_o = HOLD_UNRESOLVED;
    else if (older && (addr_q == ld_addr_i))     hold_o = HOLD_ALIAS;
  end

  assign vld_o      = vld_q;
  assign head_hit_o = head_hit;
  assign addr_vld_o = av_q;
  assign data_vld_o = dv_q;
  assign addr_o     = addr_q;
  assign data_o     = data_q;

  AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_hit_i |-> !vld_q); // R10

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && dv_q && !clr && !alloc_hit_i) |=> (dv_q && $stable(data_q))); // R7

  AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (head_hit && commit_fire_i) |=> !vld_q); // R8

  AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && vld_q && !head_hit && (age_self > age_flush)) |=> !vld_q); // R9

endmodule

// File: rtl/lsog_order_guard.sv
module lsog_order_guard
  import lsog_pkg::*;
#(
  parameter int ROB_DEPTH = 32,
  parameter int SQ_DEPTH  = 8,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  localparam int IDX_W    = $clog2(ROB_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rob_head_i,
  input  logic              st_alloc_valid_i,
  input  logic [IDX_W-1:0]  st_alloc_rob_i,
  input  logic              st_alloc_data_rdy_i,
  input  logic [DATA_W-1:0] st_alloc_data_i,
  input  logic [IDX_W-1:0]  st_alloc_tag_i,
  output logic              st_alloc_ready_o,
  input  logic              st_addr_valid_i,
  input  logic [IDX_W-1:0]  st_addr_rob_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic              res_valid_i,
  input  logic [IDX_W-1:0]  res_tag_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic              ld_req_valid_i,
  input  logic [IDX_W-1:0]  ld_req_rob_i,
  input  logic [ADDR_W-1:0] ld_req_addr_i,
  output logic              ld_grant_o,
  output logic              st_commit_valid_o,
  input  logic              st_commit_ready_i,
  output logic [ADDR_W-1:0] st_commit_addr_o,
  output logic [DATA_W-1:0] st_commit_data_o,
  input  logic              flush_i,
  input  logic [IDX_W-1:0]  flush_rob_i
);

  logic [SQ_DEPTH-1:0]             busy_vec, pick_vec, head_vec;
  logic [SQ_DEPTH-1:0]             av_vec, dv_vec, block_vec;
  logic [SQ_DEPTH-1:0][ADDR_W-1:0] addr_arr;
  logic [SQ_DEPTH-1:0][DATA_W-1:0] data_arr;
  logic                            alloc_go, commit_fire;

  // A flush in the same cycle drops the allocate.
  assign alloc_go    = st_alloc_valid_i && !flush_i;
  assign commit_fire = st_commit_valid_o && st_commit_ready_i;

  lsog_alloc #(.N(SQ_DEPTH)) u_alloc (
    .busy_i     (busy_vec),
    .req_i      (alloc_go),
    .pick_o     (pick_vec),
    .has_free_o (st_alloc_ready_o)
  );

  for (genvar g = 0; g < SQ_DEPTH; g++) begin : g_slot
    hold_e hold;
    lsog_slot #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
      .clk              (clk),
      .rst_n            (rst_n),
      .head_i           (rob_head_i),
      .alloc_hit_i      (pick_vec[g]),
      .alloc_rob_i      (st_alloc_rob_i),
      .alloc_data_rdy_i (st_alloc_data_rdy_i),
      .alloc_data_i     (st_alloc_data_i),
      .alloc_tag_i      (st_alloc_tag_i),
      .addr_we_i        (st_addr_valid_i),
      .addr_rob_i       (st_addr_rob_i),
      .addr_i           (st_addr_i),
      .res_valid_i      (res_valid_i),
      .res_tag_i        (res_tag_i),
      .res_data_i       (res_data_i),
      .flush_i          (flush_i),
      .flush_rob_i      (flush_rob_i),
      .commit_fire_i    (commit_fire),
      .ld_rob_i         (ld_req_rob_i),
      .ld_addr_i        (ld_req_addr_i),
      .vld_o            (busy_vec[g]),
      .head_hit_o       (head_vec[g]),
      .addr_vld_o       (av_vec[g]),
      .data_vld_o       (dv_vec[g]),
      .addr_o           (addr_arr[g]),
      .data_o           (data_arr[g]),
      .hold_o           (hold)
    );
    assign block_vec[g] = (hold != HOLD_NONE);
  end

  lsog_commit_mux #(.N(SQ_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmux (
    .head_hit_i (head_vec),
    .addr_vld_i (av_vec),
    .data_vld_i (dv_vec),
    .addr_i     (addr_arr),
    .data_i     (data_arr),
    .valid_o    (st_commit_valid_o),
    .addr_o     (st_commit_addr_o),
    .data_o     (st_commit_data_o)
  );

  assign ld_grant_o = ld_req_valid_i && !(|block_vec);

  AST_ONE_HEAD_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(head_vec)); // R6

  AST_COMMIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_commit_valid_o && !st_commit_ready_i) |=>
      ($stable(rob_head_i) -> (st_commit_valid_o && $stable(st_commit_addr_o)
                               && $stable(st_commit_data_o)))); // R6

  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    !st_alloc_ready_o |-> (pick_vec == '0)); // R10

  AST_NO_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_req_valid_i |-> !ld_grant_o); // R4

endmodule

// File: tb/lsog_order_guard_tb.sv
module lsog_order_guard_tb;

  localparam int RD = 16;
  localparam int SQ = 4;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [IW-1:0] rob_head_i;
  logic          st_alloc_valid_i, st_alloc_data_rdy_i;
  logic [IW-1:0] st_alloc_rob_i, st_alloc_tag_i;
  logic [DW-1:0] st_alloc_data_i;
  logic          st_alloc_ready_o;
  logic          st_addr_valid_i;
  logic [IW-1:0] st_addr_rob_i;
  logic [AW-1:0] st_addr_i;
  logic          res_valid_i;
  logic [IW-1:0] res_tag_i;
  logic [DW-1:0] res_data_i;
  logic          ld_req_valid_i;
  logic [IW-1:0] ld_req_rob_i;
  logic [AW-1:0] ld_req_addr_i;
  logic          ld_grant_o;
  logic          st_commit_valid_o, st_commit_ready_i;
  logic [AW-1:0] st_commit_addr_o;
  logic [DW-1:0] st_commit_data_o;
  logic          flush_i;
  logic [IW-1:0] flush_rob_i;

  always #10 clk = ~clk;  // 50 MHz

  lsog_order_guard #(.ROB_DEPTH(RD), .SQ_DEPTH(SQ), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rob_head_i(rob_head_i),
    .st_alloc_valid_i(st_alloc_valid_i), .st_alloc_rob_i(st_alloc_rob_i),
    .st_alloc_data_rdy_i(st_alloc_data_rdy_i), .st_alloc_data_i(st_alloc_data_i),
    .st_alloc_tag_i(st_alloc_tag_i), .st_alloc_ready_o(st_alloc_ready_o),
    .st_addr_valid_i(st_addr_valid_i), .st_addr_rob_i(st_addr_rob_i), .st_addr_i(st_addr_i),
    .res_valid_i(res_valid_i), .res_tag_i(res_tag_i), .res_data_i(res_data_i),
    .ld_req_valid_i(ld_req_valid_i), .ld_req_rob_i(ld_req_rob_i), .ld_req_addr_i(ld_req_addr_i),
    .ld_grant_o(ld_grant_o), .st_commit_valid_o(st_commit_valid_o),
    .st_commit_ready_i(st_commit_ready_i), .st_commit_addr_o(st_commit_addr_o),
    .st_commit_data_o(st_commit_data_o), .flush_i(flush_i), .flush_rob_i(flush_rob_i)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // Reference model, indexed by reorder-buffer index
  logic          m_vld [RD];
  logic          m_av  [RD];
  logic          m_dv  [RD];
  logic [AW-1:0] m_addr[RD];
  logic [DW-1:0] m_data[RD];
  logic [IW-1:0] m_tag [RD];
  logic [IW-1:0] head, tail;
  int            occ;
  int            since_flush;

  function automatic logic [IW-1:0] age(input logic [IW-1:0] idx);
    return idx - head;
  endfunction

  function automatic int live_count();
    int n = 0;
    for (int i = 0; i < RD; i++) if (m_vld[i]) n++;
    return n;
  endfunction

  function automatic logic exp_cvalid();
    return m_vld[head] && m_av[head] && m_dv[head];
  endfunction

  // Expected grant; tag names the governing requirement.
  function automatic logic exp_grant(input logic v, input logic [IW-1:0] lr,
                                     input logic [AW-1:0] la, input logic fire,
                                     output string tag);
    logic blk_u = 0, blk_a = 0, saved = 0;
    for (int i = 0; i < RD; i++) begin
      logic [IW-1:0] ii = IW'(i);
      if (m_vld[i] && age(ii) < age(lr)) begin
        logic hit = !m_av[i] || (m_addr[i] == la);
        if (fire && ii == head) saved |= hit;
        else if (!m_av[i]) blk_u = 1;
        else if (hit) blk_a = 1;
      end
    end
    if (since_flush == 0)  tag = "R9";
    else if (blk_u)        tag = "R3";
    else if (blk_a)        tag = "R2";
    else if (saved)        tag = "R8";
    else if (lr < head)    tag = "R5";
    else                   tag = "R4";
    return v && !blk_u && !blk_a;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    st_alloc_valid_i = 0; st_alloc_rob_i = '0; st_alloc_data_rdy_i = 0;
    st_alloc_data_i = '0; st_alloc_tag_i = '0; st_addr_valid_i = 0;
    st_addr_rob_i = '0; st_addr_i = '0; res_valid_i = 0; res_tag_i = '0;
    res_data_i = '0; ld_req_valid_i = 0; ld_req_rob_i = '0; ld_req_addr_i = '0;
    st_commit_ready_i = 0; flush_i = 0; flush_rob_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < RD; i++) begin
      m_vld[i] = 0; m_av[i] = 0; m_dv[i] = 0;
      m_addr[i] = '0; m_data[i] = '0; m_tag[i] = '0;
    end
    head = '0; tail = '0; occ = 0; since_flush = 5;
    rst_n = 1'b0; rob_head_i = '0;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: empty after reset
    check("R1", "alloc_ready", st_alloc_ready_o, 1);
    check("R1", "commit_valid", st_commit_valid_o, 0);
    for (int k = 0; k < 4; k++) begin
      ld_req_valid_i = 1; ld_req_rob_i = IW'(k * 5); ld_req_addr_i = AW'(k * 4);
      #1 check("R1", "grant", ld_grant_o, 1);
    end
    ld_req_valid_i = 0;
    #1 check("R4", "grant without request", ld_grant_o, 0);

    for (int cyc = 0; cyc < 6000; cyc++) begin
      logic          a_v, a_st, adv, fire, flush_now, eg;
      logic [IW-1:0] frob;
      string         tg;
      int            cnt;
      @(negedge clk);
      idle_inputs();
      cnt = live_count();
      rob_head_i = head;
      a_v  = (occ < RD) && ($urandom % 3 != 0);
      a_st = a_v && ($urandom % 2 == 0);
      st_alloc_valid_i    = a_st;
      st_alloc_rob_i      = tail;
      st_alloc_data_rdy_i = ($urandom % 2 == 0);
      st_alloc_data_i     = DW'($urandom);
      st_alloc_tag_i      = head + IW'($urandom % (occ + 1));
      begin
        logic [IW-1:0] cand = head + IW'($urandom % RD);
        if (age(cand) < IW'(occ) && occ > 0 && m_vld[cand] && !m_av[cand]
            && ($urandom % 2 == 0)) begin
          st_addr_valid_i = 1; st_addr_rob_i = cand;
          st_addr_i = AW'(($urandom % 4) * 4);
        end
      end
      res_valid_i = ($urandom % 2 == 0);
      res_tag_i   = IW'($urandom);
      res_data_i  = DW'($urandom);
      ld_req_valid_i = ($urandom % 4 != 0);
      ld_req_rob_i   = head + IW'($urandom % ((occ < RD) ? occ + 1 : RD));
      ld_req_addr_i  = AW'(($urandom % 4) * 4);
      st_commit_ready_i = ($urandom % 4 != 0);
      adv = (occ > 0) && !m_vld[head] && ($urandom % 2 == 0);
      flush_now = (occ > 0) && ($urandom % 40 == 0);
      frob = head + IW'((occ > 0) ? $urandom % occ : 0);
      flush_i = flush_now; flush_rob_i = frob;
      #1;
      fire = exp_cvalid() && st_commit_ready_i;
      check("R10", "alloc_ready", st_alloc_ready_o, (cnt < SQ));
      check((since_flush == 0) ? "R9" : "R6", "commit_valid", st_commit_valid_o, exp_cvalid());
      if (exp_cvalid()) begin
        check("R6", "commit_addr", st_commit_addr_o, m_addr[head]);
        check("R7", "commit_data", st_commit_data_o, m_data[head]);
      end
      eg = exp_grant(ld_req_valid_i, ld_req_rob_i, ld_req_addr_i, fire, tg);
      check(tg, "grant", ld_grant_o, eg);
      @(posedge clk);
      // Model update, using the inputs held through this edge
      since_flush = flush_now ? 0 : since_flush + 1;
      if (flush_now) begin
        for (int i = 0; i < RD; i++)
          if (m_vld[i] && age(IW'(i)) > age(frob)) m_vld[i] = 0;
        occ  = int'(age(frob)) + 1;
        tail = frob + 1'b1;
      end
      for (int i = 0; i < RD; i++)
        if (m_vld[i] && !m_dv[i] && res_valid_i && res_tag_i == m_tag[i]) begin
          m_dv[i] = 1; m_data[i] = res_data_i;
        end
      if (st_addr_valid_i && m_vld[st_addr_rob_i]) begin
        m_av[st_addr_rob_i] = 1; m_addr[st_addr_rob_i] = st_addr_i;
      end
      if (fire) m_vld[head] = 0;
      if (a_v && !flush_now) begin
        if (!a_st || cnt < SQ) begin
          if (a_st) begin
            m_vld[tail] = 1; m_av[tail] = 0; m_tag[tail] = st_alloc_tag_i;
            m_dv[tail] = st_alloc_data_rdy_i || (res_valid_i && res_tag_i == st_alloc_tag_i);
            m_data[tail] = st_alloc_data_rdy_i ? st_alloc_data_i : res_data_i;
          end
          tail = tail + 1'b1;
          occ++;
        end
      end
      if (fire || adv) begin
        head = head + 1'b1;
        occ--;
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule